// File: doc/BRIEF.md
# Splittable Performance Counter Bank

The block holds a bank of physical event counters behind a small register port. Each physical counter counts as one 32-bit value, or it splits into two independent 16-bit counters. A per-counter bit in a global control register picks the mode. Event pulses arrive on one input per logical counter. In the default configuration there are eight physical counters and sixteen logical ones. Logical counter n drives the whole counter n, or only its upper half when the counter is split. Logical counter n+8 drives the lower half of counter n, and it counts only when that counter is split.

Software does not write a running counter directly. A write to a counter lands in a holding latch for that counter. Reading the counter then returns the latch while the latch holds a value that has not yet been committed. Every latched value moves into its live counter when the control register is written with its enable bit set. This happens even when the monitor is already enabled, so a rewrite of the control register acts as a commit. A counter, or a half of a split counter, that wraps while counting raises a sticky overflow bit in a status register. Reading the status register clears those bits. Writing the status register sets the interrupt mask, and the interrupt line is high while any pending bit is also unmasked.

Top module: `split_ctr_bank`

## Requirements
- R1: Registers sit at an 8-byte stride, selected by address bits [7:3]; address bits [2:0] are ignored. Index 0-7 selects a physical counter, index 8 the control register and index 9 the status register; every other index reads as zero. Each register is 32 bits wide and travels on bus bits [63:32]. Bits [31:0] of the write data are ignored, and bits [31:0] of the read data are zero. Read data is registered: it appears on the clock edge that samples the read strobe and holds until the next read.
- R2: When control bit i is 0, physical counter i adds one at each clock edge where the monitor is enabled and event input i is high. Event input i+8 has no effect on it.
- R3: When control bit i is 1, bits [31:16] of counter i count event input i and bits [15:0] count event input i+8. Each half wraps within itself, and no carry passes from the lower half to the upper half.
- R4: A write to counter i stores the value in that counter's latch and leaves the live count unchanged. Reads of counter i return the latch until a commit, and return the live count at all other times.
- R5: A control write with bit 31 set copies every pending latch into its live counter and clears all pending flags, whether or not the monitor was already enabled. A counter loaded this way does not count on the commit edge.
- R6: While control bit 31 is clear, no counter changes except through a commit.
- R7: A wrap from all ones to zero while counting sets a status bit. A 32-bit counter i sets bit i. A split counter i sets bit i for its upper half and bit i+8 for its lower half.
- R8: A status read returns the pending bits and clears them on the same edge. An overflow that occurs on that same edge stays pending.
- R9: A status write loads bits [15:0] as the interrupt mask. The interrupt output is high while a pending bit has its mask bit set, so a zero mask keeps it low.
- R10: Reset clears all counters, latches, pending flags, control, mask, status and the read data.
- R11: A control write with bit 31 clear commits nothing: latched values stay pending and the live counters stay as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 8 | Byte address of the register |
| regWdata | input | 64 | Write data; register value in [63:32] |
| evtIn | input | 16 | One event pulse per logical counter |
| regRdata | output | 64 | Registered read data; value in [63:32] |
| irq | output | 1 | High while an unmasked overflow is pending |

## Verification
Counter and status updates take effect on the same clock edge that samples the event or write. Read data appears on the edge that samples the read strobe, so a read issued one cycle after an event already shows that event. The interrupt output is driven combinationally from the pending and mask registers, so it follows the edge that set or cleared a pending bit with no further delay. The bench drives its inputs on falling edges. Its reference model advances on each rising edge, and the read data and interrupt output are compared against the model on every falling edge, which keeps each comparison aligned with the cycle in which the result is due.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  localparam int PHYS_N = 8;
  localparam int CNT_W  = 32;
  localparam int IDX_W  = $clog2(PHYS_N);

  // Control-to-datapath strobes for one clock cycle
  typedef struct packed {
    logic             latchWe;   // software write into one holding latch
    logic [IDX_W-1:0] latchIdx;  // which physical counter's latch
    logic             commit;    // copy pending latches into live counters
    logic             countEn;   // monitor running
    logic [CNT_W-1:0] data;      // register word from the bus
  } strobe_t;
endpackage

// File: rtl/pcb_slice.sv
`timescale 1ns/1ps
module pcb_slice import pcb_pkg::*; #(
  parameter int CntW = CNT_W,
  parameter int Idx  = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic            split,
  input  logic            evtHi,
  input  logic            evtLo,
  output logic [CntW-1:0] rdVal,
  output logic            ovfHi,
  output logic            ovfLo
);
  localparam int Half = CntW / 2;

  logic [CntW-1:0] live, latchQ, liveNext;
  logic            pend;
  logic [Half-1:0] hiPart, loPart;
  logic            myWr, doCommit;

  assign myWr     = stb.latchWe && (stb.latchIdx == IDX_W'(Idx));
  assign doCommit = stb.commit && pend;
  assign hiPart   = live[CntW-1:Half];
  assign loPart   = live[Half-1:0];

  always_comb begin
    liveNext = live;
    ovfHi    = 1'b0;
    ovfLo    = 1'b0;
    if (doCommit) begin
      liveNext = latchQ;
    end else if (stb.countEn) begin
      if (split) begin
        liveNext = {hiPart + Half'(evtHi), loPart + Half'(evtLo)};
        ovfHi    = evtHi && (&hiPart);
        ovfLo    = evtLo && (&loPart);
      end else begin
        liveNext = live + CntW'(evtHi);
        ovfHi    = evtHi && (&live);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live   <= '0;
      latchQ <= '0;
      pend   <= 1'b0;
    end else begin
      live <= liveNext;
      if (myWr) begin
        latchQ <= stb.data;
        pend   <= 1'b1;
      end else if (stb.commit) begin
        pend <= 1'b0;
      end
    end
  end

  // newer value wins: a pending latch shadows the live count
  assign rdVal = pend ? latchQ : live;

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (myWr && !stb.countEn) |=> $stable(live));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.countEn && !stb.commit) |=> $stable(live));
  // R5
  commit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && pend) |=> ((live == $past(latchQ)) && !pend));
  // R3
  no_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countEn && split && !stb.commit && !evtLo) |=> $stable(live[Half-1:0]));
endmodule

// File: rtl/pcb_datapath.sv
`timescale 1ns/1ps
module pcb_datapath import pcb_pkg::*; #(
  parameter int NPhys = PHYS_N,
  parameter int CntW  = CNT_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [NPhys-1:0]           split,
  input  logic [2*NPhys-1:0]         evt,
  output logic [NPhys-1:0][CntW-1:0] rdVals,
  output logic [2*NPhys-1:0]         ovf
);
  for (genvar g = 0; g < NPhys; g++) begin : gSlice
    pcb_slice #(.CntW(CntW), .Idx(g)) uSlice (
      .clk   (clk),
      .rstN  (rstN),
      .stb   (stb),
      .split (split[g]),
      .evtHi (evt[g]),
      .evtLo (evt[g+NPhys]),
      .rdVal (rdVals[g]),
      .ovfHi (ovf[g]),
      .ovfLo (ovf[g+NPhys])
    );
  end
endmodule

// File: rtl/pcb_ctrl.sv
`timescale 1ns/1ps
module pcb_ctrl import pcb_pkg::*; #(
  parameter int NPhys = PHYS_N,
  parameter int CntW  = CNT_W,
  parameter int AddrW = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWe,
  input  logic                       regRe,
  input  logic [AddrW-1:0]           regAddr,
  input  logic [2*CntW-1:0]          regWdata,
  input  logic [NPhys-1:0][CntW-1:0] rdVals,
  input  logic [2*NPhys-1:0]         ovf,
  output strobe_t                    stb,
  output logic [NPhys-1:0]           split,
  output logic [2*CntW-1:0]          regRdata,
  output logic                       irq
);
  localparam int LogN    = 2 * NPhys;
  localparam int BusW    = 2 * CntW;
  localparam int EnBit   = CntW - 1;
  localparam int RegIdxW = AddrW - 3;
  localparam int SelW    = $clog2(NPhys);
  localparam int CtrlIdx = NPhys;
  localparam int StatIdx = NPhys + 1;

  logic [RegIdxW-1:0] idx;
  logic [CntW-1:0]    wrWord, rdMux, rdQ;
  logic               isCnt, isCtrl, isStat, statRd;
  logic               ctrlEn;
  logic [LogN-1:0]    mask, pending;
  logic               unusedBits;

  assign idx        = regAddr[AddrW-1:3];
  assign wrWord     = regWdata[BusW-1:CntW];
  assign unusedBits = ^{regWdata[CntW-1:0], regAddr[2:0]};

  assign isCnt  = idx < RegIdxW'(NPhys);
  assign isCtrl = idx == RegIdxW'(CtrlIdx);
  assign isStat = idx == RegIdxW'(StatIdx);
  assign statRd = regRe && isStat;

  always_comb begin
    stb.latchWe  = regWe && isCnt;
    stb.latchIdx = IDX_W'(idx);
    stb.commit   = regWe && isCtrl && wrWord[EnBit];
    stb.countEn  = ctrlEn;
    stb.data     = wrWord;
  end

  always_comb begin
    rdMux = '0;
    if (isCnt) begin
      rdMux = rdVals[idx[SelW-1:0]];
    end else if (isCtrl) begin
      rdMux[EnBit]     = ctrlEn;
      rdMux[NPhys-1:0] = split;
    end else if (isStat) begin
      rdMux[LogN-1:0] = pending;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      split   <= '0;
      mask    <= '0;
      pending <= '0;
      rdQ     <= '0;
    end else begin
      if (regWe && isCtrl) begin
        ctrlEn <= wrWord[EnBit];
        split  <= wrWord[NPhys-1:0];
      end
      if (regWe && isStat) mask <= wrWord[LogN-1:0];
      // a new overflow wins over the clear of a read in the same cycle
      pending <= (pending & ~{LogN{statRd}}) | ovf;
      if (regRe) rdQ <= rdMux;
    end
  end

  assign regRdata = {rdQ, {CntW{1'b0}}};
  assign irq      = |(pending & mask);

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> (pending == $past(ovf)));
  // R9
  mask_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && isStat && (wrWord[LogN-1:0] == '0)) |=> !irq);
  // R1
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRe |=> $stable(regRdata));
endmodule

// File: rtl/split_ctr_bank.sv
`timescale 1ns/1ps
module split_ctr_bank import pcb_pkg::*; #(
  parameter int NPhys = PHYS_N,
  parameter int CntW  = CNT_W,
  parameter int AddrW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic                regRe,
  input  logic [AddrW-1:0]    regAddr,
  input  logic [2*CntW-1:0]   regWdata,
  input  logic [2*NPhys-1:0]  evtIn,
  output logic [2*CntW-1:0]   regRdata,
  output logic                irq
);
  strobe_t                    stb;
  logic [NPhys-1:0]           split;
  logic [NPhys-1:0][CntW-1:0] rdVals;
  logic [2*NPhys-1:0]         ovf;

  pcb_ctrl #(.NPhys(NPhys), .CntW(CntW), .AddrW(AddrW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regRe    (regRe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .rdVals   (rdVals),
    .ovf      (ovf),
    .stb      (stb),
    .split    (split),
    .regRdata (regRdata),
    .irq      (irq)
  );

  pcb_datapath #(.NPhys(NPhys), .CntW(CntW)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .split  (split),
    .evt    (evtIn),
    .rdVals (rdVals),
    .ovf    (ovf)
  );
endmodule

// File: tb/sim_split_ctr_bank.sv
`timescale 1ns/1ps
module sim_split_ctr_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [15:0] evt = '0;
  logic [63:0] rdata;
  logic        irq;

  int    total = 0, fails = 0;
  bit    chkOn = 1'b0;
  string phase = "R10";

  // reference model state
  logic [31:0] mLive [8];
  logic [31:0] mLatch [8];
  bit          mPend [8];
  logic [31:0] mCtrl = '0, mRd = '0;
  logic [15:0] mMask = '0, mStat = '0;
  logic [31:0] nl [8];
  logic [31:0] w;
  logic [15:0] ovf, hi, lo;
  int          ix;
  bit          commit;

  always #10 clk = ~clk;

  split_ctr_bank u0 (
    .clk(clk), .rstN(rstN), .regWe(we), .regRe(re), .regAddr(addr),
    .regWdata(wdata), .evtIn(evt), .regRdata(rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin
        mLive[i] = '0; mLatch[i] = '0; mPend[i] = 1'b0;
      end
      mCtrl = '0; mRd = '0; mMask = '0; mStat = '0;
    end else begin
      w      = wdata[63:32];
      ix     = int'(addr[7:3]);
      ovf    = '0;
      commit = we && ix == 8 && w[31];
      for (int i = 0; i < 8; i++) begin
        nl[i] = mLive[i];
        if (commit && mPend[i]) nl[i] = mLatch[i];
        else if (mCtrl[31]) begin
          if (mCtrl[i]) begin
            hi = mLive[i][31:16];
            lo = mLive[i][15:0];
            if (evt[i]) begin
              if (hi == 16'hFFFF) ovf[i] = 1'b1;
              hi = hi + 16'd1;
            end
            if (evt[i+8]) begin
              if (lo == 16'hFFFF) ovf[i+8] = 1'b1;
              lo = lo + 16'd1;
            end
            nl[i] = {hi, lo};
          end else if (evt[i]) begin
            if (mLive[i] == 32'hFFFF_FFFF) ovf[i] = 1'b1;
            nl[i] = mLive[i] + 32'd1;
          end
        end
      end
      if (re) begin
        if (ix < 8) mRd = mPend[ix] ? mLatch[ix] : mLive[ix];
        else if (ix == 8) mRd = mCtrl;
        else if (ix == 9) mRd = {16'h0, mStat};
        else mRd = '0;
      end
      mStat = ((re && ix == 9) ? 16'h0 : mStat) | ovf;
      for (int i = 0; i < 8; i++) mLive[i] = nl[i];
      if (commit) for (int i = 0; i < 8; i++) mPend[i] = 1'b0;
      if (we && ix < 8) begin
        mLatch[ix] = w;
        mPend[ix]  = 1'b1;
      end
      if (we && ix == 8) mCtrl = w & 32'h8000_00FF;
      if (we && ix == 9) mMask = w[15:0];
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      check(rdata === {mRd, 32'h0}, "read data", rdata, {mRd, 32'h0});
      check(irq === |(mStat & mMask), "interrupt", 64'(irq), 64'(|(mStat & mMask)));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic wr(input int idx, input logic [31:0] val);
    @(negedge clk);
    we = 1'b1; addr = 8'(idx << 3); wdata = {val, 32'hA5A5_5A5A};
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int idx);
    @(negedge clk);
    re = 1'b1; addr = 8'((idx << 3) | 3);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic pulse(input int n, input logic [15:0] e);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      evt = e;
    end
    @(negedge clk);
    evt = '0;
  endtask

  task automatic rd_all();
    for (int k = 0; k < 10; k++) rd(k);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state at the ports
    check(rdata === 64'h0, "reset read data", rdata, 64'h0);
    check(irq === 1'b0, "reset interrupt", 64'(irq), 64'h0);
    rstN = 1'b1;
    chkOn = 1'b1;
    phase = "R10"; rd_all();

    phase = "R2";
    wr(8, 32'h8000_0000);
    pulse(5, 16'h00FF);
    pulse(4, 16'hFF00);
    pulse(3, 16'h0055);
    rd_all();

    phase = "R3";
    wr(8, 32'h8000_0005);
    for (int k = 0; k < 20; k++) pulse(1, 16'($urandom));
    pulse(6, 16'h0500);
    rd_all();

    phase = "R4";
    wr(1, 32'h0000_1234);
    rd(1);
    pulse(4, 16'h0002);
    rd(1); rd(3);

    phase = "R11";
    wr(8, 32'h0000_0005);
    rd(1); rd(8);
    phase = "R6";
    pulse(5, 16'hFFFF);
    rd_all();

    phase = "R5";
    wr(8, 32'h8000_0005);
    rd(1);
    pulse(3, 16'h0006);
    wr(2, 32'h0000_7000);
    wr(8, 32'h8000_0005);
    rd(2); rd(1);

    phase = "R9";
    wr(9, 32'h0000_FFFF);
    phase = "R7";
    wr(8, 32'h8000_0004);
    wr(0, 32'hFFFF_FFFE);
    wr(2, 32'hFFFF_FFFF);
    wr(8, 32'h8000_0004);
    pulse(3, 16'h0405);
    rd(9); rd(0); rd(2);

    phase = "R8";
    wr(3, 32'hFFFF_FFFF);
    wr(8, 32'h8000_0000);
    @(negedge clk);
    re = 1'b1; addr = 8'(9 << 3); evt = 16'h0008;
    @(negedge clk);
    re = 1'b0; evt = '0;
    rd(9); rd(9);

    phase = "R9";
    wr(3, 32'hFFFF_FFFF);
    wr(8, 32'h8000_0000);
    wr(9, 32'h0000_0000);
    pulse(1, 16'h0008);
    wr(9, 32'h0000_0008);
    rd(9);

    phase = "R1";
    rd(12); rd(31);
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      we = ($urandom % 4) == 0;
      re = !we && (($urandom % 3) == 0);
      addr = 8'({5'($urandom % 12), 3'($urandom)});
      wdata = {(($urandom % 2) == 0) ? 32'hFFFF_FFF0 | 32'($urandom % 16) : 32'($urandom), 32'($urandom)};
      if (we && addr[7:3] == 5'd8 && ($urandom % 4) != 0) wdata[63] = 1'b1;
      evt = 16'($urandom);
    end
    @(negedge clk);
    we = 1'b0; re = 1'b0; evt = '0;
    rd_all();
    @(negedge clk);
    finish_run();
  end
endmodule